// File: doc/BRIEF.md
# Reset supervisor with watchdog

This block produces the system reset for a processor subsystem. It watches two supply-good levels (the main rail and one auxiliary rail, both already compared to their thresholds outside the block), an active-low push-button or controller reset request, and a watchdog kick line driven by software. Reset asserts when any of these conditions appears:

- power-on reset is applied;
- either supply-good level drops;
- the manual request is held long enough to pass the debounce filter;
- software fails to toggle the kick line in time.

Reset is then stretched for a fixed hold time after the last cause clears.

The watchdog gives software a long first window after power-up or a supply dip, so that boot code can run. After that first window, and after any watchdog or manual reset, the window is short. A rising or a falling transition of the kick line restarts the window. The watchdog is frozen at zero while reset is asserted. Every duration is a parameter in clock cycles, and all asynchronous inputs are brought into the clock domain by a synchroniser of `SYNC_STAGES` flops. The reset is driven in both polarities.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high, `reset_o` is 1 and `reset_n_o` is 0. After `rst` falls with both supplies good, `reset_o` stays high for HOLD_CYCLES+SYNC_STAGES-1 further cycles, then falls.
- R2: `reset_n_o` is always the inverse of `reset_o`.
- R3: Either supply-good input at 0 for P>=1 cycles, starting from a released state, produces a reset pulse of exactly P+HOLD_CYCLES-1 cycles.
- R4: `mr_n_i` at 0 for P>=MR_DEBOUNCE_CYCLES cycles produces a reset pulse of exactly P+HOLD_CYCLES-1 cycles. A low pulse shorter than MR_DEBOUNCE_CYCLES leaves `reset_o` at 0.
- R5: A watchdog-caused reset pulse lasts exactly HOLD_CYCLES cycles. Reset never falls until the hold counter has run HOLD_CYCLES cycles with no cause present.
- R6: After a power-on or supply-caused reset, with no kicks, reset re-asserts WD_START_CYCLES+1 cycles after it released.
- R7: After a watchdog-caused or manual reset, with no kicks, reset re-asserts WD_NORMAL_CYCLES+1 cycles after it released. Each expiry is a single-cycle event.
- R8: Any change of `kick_i`, whether 0 to 1 or 1 to 0, restarts the watchdog in its short period. Reset then re-asserts WD_NORMAL_CYCLES+SYNC_STAGES+1 cycles after the cycle in which `kick_i` changed.
- R9: The watchdog count is held at zero and cannot expire while reset is asserted.
- R10: Kicks spaced closer than WD_NORMAL_CYCLES cycles keep `reset_o` at 0 indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| vdd_ok_i | input | 1 | Main supply above threshold (asynchronous) |
| aux_ok_i | input | 1 | Auxiliary monitored rail above threshold (asynchronous) |
| mr_n_i | input | 1 | Manual reset request, active low (asynchronous) |
| kick_i | input | 1 | Watchdog kick; either edge restarts the window (asynchronous) |
| reset_o | output | 1 | System reset, active high |
| reset_n_o | output | 1 | System reset, active low |

## Verification
The embedded properties check, on every cycle, several local rules:

- any present cause forces reset on the next edge;
- reset only falls at the end of a complete hold count;
- the debounced request only flips after a full qualifying run;
- a kick edge zeroes the watchdog count, which stays idle during reset;
- a supply fault selects the long window;
- expiry is a one-cycle pulse.

The exact durations come from chains of synchroniser, debounce, watchdog and hold registers, so only the bench scenarios can show them. These durations are the pulse width for each cause and each pulse length, the long-versus-short window selection after each kind of reset, the response to both kick polarities, and the rejection of short manual pulses. They are measured as run lengths of the reset output.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    // Positions inside the synchronised input vector.
    localparam int unsigned SYNC_W   = 4;
    localparam int unsigned BIT_VDD  = 3;
    localparam int unsigned BIT_AUX  = 2;
    localparam int unsigned BIT_MRN  = 1;
    localparam int unsigned BIT_KICK = 0;

    // Safe values held by the synchroniser during power-on reset:
    // supplies reported bad, manual request idle (high), kick low.
    localparam logic [SYNC_W-1:0] SYNC_SAFE = 4'b0010;

    typedef enum logic {
        WD_START  = 1'b0,
        WD_NORMAL = 1'b1
    } wd_mode_e;

    typedef struct packed {
        logic supply;
        logic manual;
        logic watchdog;
    } rst_cause_t;

    // Bits needed to count 0 .. n-1.
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    function automatic logic cause_any(input rst_cause_t c);
        return c.supply | c.manual | c.watchdog;
    endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int unsigned WIDTH = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [WIDTH-1:0] q;
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q <= RESET_VAL;
                else     q <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q <= RESET_VAL;
                else     q <= g_stage[i-1].q;
            end
        end
    end

    assign q_o = g_stage[STAGES-1].q;

endmodule

// File: rtl/rsup_debounce.sv
module rsup_debounce
    import rsup_pkg::*;
#(
    parameter int unsigned CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic active_o
);

    localparam int unsigned CW = cnt_bits(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          active_q;

    // The filtered level follows the raw level only after the raw level
    // has disagreed with it on CYCLES consecutive edges.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (raw_i != active_q) begin
            if (cnt_q == LAST) begin
                cnt_q    <= '0;
                active_q <= raw_i;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign active_o = active_q;

    assert_flip_after_run_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_q) |-> ($past(raw_i) == active_q && $past(cnt_q) == LAST));

endmodule

// File: rtl/rsup_watchdog.sv
module rsup_watchdog
    import rsup_pkg::*;
#(
    parameter int unsigned START_CYCLES = 120,
    parameter int unsigned NORMAL_CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_i,
    input  logic hold_i,
    input  logic clear_i,
    input  logic supply_fail_i,
    output logic expire_o
);

    localparam int unsigned LIMIT_MAX =
        (START_CYCLES > NORMAL_CYCLES) ? START_CYCLES : NORMAL_CYCLES;
    localparam int unsigned CW = cnt_bits(LIMIT_MAX);
    localparam logic [CW-1:0] START_LAST  = CW'(START_CYCLES - 1);
    localparam logic [CW-1:0] NORMAL_LAST = CW'(NORMAL_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          kick_prev_q;
    logic          expire_q;
    wd_mode_e      mode_q;
    logic          kick_edge;
    logic [CW-1:0] limit_last;

    assign kick_edge  = kick_i ^ kick_prev_q;
    assign limit_last = (mode_q == WD_START) ? START_LAST : NORMAL_LAST;

    // Window selection: a supply fault (or power-on) re-arms the long
    // window; an expiry, a manual request or a kick while running moves
    // to the short one.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= WD_START;
        end else if (supply_fail_i) begin
            mode_q <= WD_START;
        end else if (clear_i || expire_q || (kick_edge && !hold_i)) begin
            mode_q <= WD_NORMAL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            kick_prev_q <= 1'b0;
            expire_q    <= 1'b0;
        end else begin
            kick_prev_q <= kick_i;
            expire_q    <= 1'b0;
            if (hold_i || clear_i || kick_edge) begin
                cnt_q <= '0;
            end else if (cnt_q == limit_last) begin
                cnt_q    <= '0;
                expire_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign expire_o = expire_q;

    assert_idle_in_reset_R9: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> (cnt_q == '0 && !expire_q));

    assert_kick_clears_R8: assert property (@(posedge clk) disable iff (rst)
        kick_edge |=> (cnt_q == '0));

    assert_long_after_supply_R6: assert property (@(posedge clk) disable iff (rst)
        supply_fail_i |=> (mode_q == WD_START));

    assert_expire_single_R7: assert property (@(posedge clk) disable iff (rst)
        expire_q |=> !expire_q);

endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch
    import rsup_pkg::*;
#(
    parameter int unsigned HOLD = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic cause_i,
    output logic reset_o
);

    localparam int unsigned CW = cnt_bits(HOLD);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD - 1);

    logic [CW-1:0] cnt_q;
    logic          reset_q;

    always_ff @(posedge clk) begin
        if (rst || cause_i) begin
            reset_q <= 1'b1;
            cnt_q   <= '0;
        end else if (reset_q) begin
            if (cnt_q == HOLD_LAST) begin
                reset_q <= 1'b0;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign reset_o = reset_q;

    assert_cause_asserts_R3: assert property (@(posedge clk) disable iff (rst)
        cause_i |=> reset_q);

    assert_hold_release_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(reset_q) |-> ($past(cnt_q) == HOLD_LAST && !$past(cause_i)));

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rsup_pkg::*;
#(
    // Defaults sized for a 10 MHz clock.
    parameter int unsigned SYNC_STAGES        = 2,
    parameter int unsigned MR_DEBOUNCE_CYCLES = 8,
    parameter int unsigned HOLD_CYCLES        = 2_000_000,
    parameter int unsigned WD_START_CYCLES    = 510_000_000,
    parameter int unsigned WD_NORMAL_CYCLES   = 16_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic vdd_ok_i,
    input  logic aux_ok_i,
    input  logic mr_n_i,
    input  logic kick_i,
    output logic reset_o,
    output logic reset_n_o
);

    logic [SYNC_W-1:0] raw_vec;
    logic [SYNC_W-1:0] sync_vec;
    logic              mr_active;
    logic              wd_expire;
    logic              hold_q;
    rst_cause_t        cause;

    assign raw_vec = {vdd_ok_i, aux_ok_i, mr_n_i, kick_i};

    rsup_sync #(
        .WIDTH     (SYNC_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (SYNC_SAFE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_vec),
        .q_o (sync_vec)
    );

    rsup_debounce #(
        .CYCLES (MR_DEBOUNCE_CYCLES)
    ) u_debounce (
        .clk      (clk),
        .rst      (rst),
        .raw_i    (~sync_vec[BIT_MRN]),
        .active_o (mr_active)
    );

    always_comb begin
        cause.supply   = ~(sync_vec[BIT_VDD] & sync_vec[BIT_AUX]);
        cause.manual   = mr_active;
        cause.watchdog = wd_expire;
    end

    rsup_watchdog #(
        .START_CYCLES  (WD_START_CYCLES),
        .NORMAL_CYCLES (WD_NORMAL_CYCLES)
    ) u_watchdog (
        .clk           (clk),
        .rst           (rst),
        .kick_i        (sync_vec[BIT_KICK]),
        .hold_i        (hold_q),
        .clear_i       (mr_active),
        .supply_fail_i (cause.supply),
        .expire_o      (wd_expire)
    );

    rsup_stretch #(
        .HOLD (HOLD_CYCLES)
    ) u_stretch (
        .clk     (clk),
        .rst     (rst),
        .cause_i (cause_any(cause)),
        .reset_o (hold_q)
    );

    assign reset_o   = hold_q;
    assign reset_n_o = ~hold_q;

endmodule

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;

    localparam int SYNC   = 2;
    localparam int DEB    = 4;
    localparam int HOLD   = 20;
    localparam int START  = 120;
    localparam int NORMAL = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vdd_ok = 1'b1;
    logic aux_ok = 1'b1;
    logic mr_n = 1'b1;
    logic kick = 1'b0;
    logic reset_o;
    logic reset_n_o;

    always #5 clk = ~clk;

    rst_supervisor #(
        .SYNC_STAGES        (SYNC),
        .MR_DEBOUNCE_CYCLES (DEB),
        .HOLD_CYCLES        (HOLD),
        .WD_START_CYCLES    (START),
        .WD_NORMAL_CYCLES   (NORMAL)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .vdd_ok_i  (vdd_ok),
        .aux_ok_i  (aux_ok),
        .mr_n_i    (mr_n),
        .kick_i    (kick),
        .reset_o   (reset_o),
        .reset_n_o (reset_n_o)
    );

    int tests = 0;
    int fails = 0;
    int hi_len = 0;
    int lo_len = 0;
    int run_len = 0;
    logic run_val = 1'b1;
    int high_total = 0;
    int comp_err = 0;
    bit finished = 0;

    // Run-length monitor of the reset output, sampled mid-cycle.
    always @(negedge clk) begin
        if (reset_o === run_val) begin
            run_len++;
        end else begin
            if (run_val) hi_len = run_len;
            else         lo_len = run_len;
            run_val = reset_o;
            run_len = 1;
        end
        if (reset_o === 1'b1) high_total++;
        if (reset_n_o !== ~reset_o) comp_err++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_level(input logic v, input int maxc, input string req);
        int n = 0;
        bit got = 0;
        while (!got && n < maxc) begin
            @(negedge clk);
            #1;
            n++;
            if (reset_o === v) got = 1;
        end
        if (!got) check(1'b0, {req, " timeout waiting for reset level"}, n, maxc);
    endtask

    initial begin
        int n;
        int base;

        // R1: state during power-on reset
        repeat (3) @(negedge clk);
        check(reset_o === 1'b1, "R1 reset_o during rst", int'(reset_o), 1);
        check(reset_n_o === 1'b0, "R2 reset_n_o during rst", int'(reset_n_o), 0);

        // R1: release time after rst
        @(negedge clk);
        rst = 1'b0;
        n = 0;
        forever begin
            @(negedge clk);
            #1;
            if (reset_o !== 1'b1 || n > HOLD + 50) break;
            n++;
        end
        check(n == HOLD + SYNC - 1, "R1 power-on hold", n, HOLD + SYNC - 1);

        // R6: long first window, R5: watchdog pulse, R7: short window after expiry
        wait_level(1'b1, START + 50, "R6");
        check(lo_len == START + 1, "R6 startup window", lo_len, START + 1);
        wait_level(1'b0, HOLD + 50, "R5");
        check(hi_len == HOLD, "R5 watchdog pulse width", hi_len, HOLD);
        wait_level(1'b1, NORMAL + 50, "R7");
        check(lo_len == NORMAL + 1, "R7 window after expiry", lo_len, NORMAL + 1);
        wait_level(1'b0, HOLD + 50, "R5");
        check(hi_len == HOLD, "R5 second watchdog pulse", hi_len, HOLD);

        // R10: regular kicks keep reset released
        base = high_total;
        for (int k = 0; k < 6; k++) begin
            repeat (NORMAL - 10) @(negedge clk);
            kick = ~kick;
        end
        repeat (10) @(negedge clk);
        #1;
        check(high_total == base, "R10 kicked run stays released", high_total - base, 0);

        // R3: supply drops of several lengths on either rail
        for (int i = 0; i < 3; i++) begin
            int p;
            p = (i == 0) ? 1 : ((i == 1) ? 3 : 6);
            @(negedge clk);
            if (i % 2 == 0) vdd_ok = 1'b0;
            else            aux_ok = 1'b0;
            repeat (p) @(negedge clk);
            vdd_ok = 1'b1;
            aux_ok = 1'b1;
            wait_level(1'b1, 50, "R3");
            wait_level(1'b0, HOLD + 50, "R3");
            check(hi_len == p + HOLD - 1, "R3 supply pulse width", hi_len, p + HOLD - 1);
        end

        // R6: supply fault re-arms the long window
        wait_level(1'b1, START + 50, "R6");
        check(lo_len == START + 1, "R6 window after supply fault", lo_len, START + 1);
        wait_level(1'b0, HOLD + 50, "R5");
        check(hi_len == HOLD, "R5 pulse after supply window", hi_len, HOLD);

        // R8: kick edges of both polarities, starting from the long window
        @(negedge clk);
        aux_ok = 1'b0;
        repeat (2) @(negedge clk);
        aux_ok = 1'b1;
        wait_level(1'b1, 50, "R3");
        wait_level(1'b0, HOLD + 50, "R3");
        check(hi_len == 2 + HOLD - 1, "R3 aux pulse width", hi_len, 2 + HOLD - 1);
        for (int e = 0; e < 2; e++) begin
            repeat (10) @(negedge clk);
            kick = ~kick;
            wait_level(1'b1, START + 50, "R8");
            check(lo_len == NORMAL + 10 + SYNC + 2, e == 0 ? "R8 rising kick" : "R8 falling kick",
                  lo_len, NORMAL + 10 + SYNC + 2);
            wait_level(1'b0, HOLD + 50, "R8");
        end

        // R4: manual pulses swept across the debounce length
        for (int p = 1; p <= DEB + 2; p++) begin
            @(negedge clk);
            kick = ~kick;
            repeat (4) @(negedge clk);
            base = high_total;
            mr_n = 1'b0;
            repeat (p) @(negedge clk);
            mr_n = 1'b1;
            if (p < DEB) begin
                repeat (2 * DEB + 6) @(negedge clk);
                #1;
                check(high_total == base, "R4 short manual pulse ignored", high_total - base, 0);
            end else begin
                wait_level(1'b1, 50, "R4");
                wait_level(1'b0, HOLD + 50, "R4");
                check(hi_len == p + HOLD - 1, "R4 manual pulse width", hi_len, p + HOLD - 1);
                wait_level(1'b1, START + 50, "R7");
                check(lo_len == NORMAL + 1, "R7 window after manual reset", lo_len, NORMAL + 1);
                wait_level(1'b0, HOLD + 50, "R5");
            end
        end

        // R2: complement held throughout
        check(comp_err == 0, "R2 outputs complementary", comp_err, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog R1-sequence hung: got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule